// File: doc/BRIEF.md
# FIFO Channel with Replay and Overwrite Marks

This block is a synchronous first-in first-out channel of 18-bit words whose depth is a parameter, 512 or 1024 words. Besides its live read and write pointers it keeps two saved marks, one for each side. A strobe copies a live pointer into its mark, and another strobe copies the mark back into the live pointer. A consumer can therefore note where a block of data starts, read the block, and then rewind to read it again. A producer can likewise rewind and write over a block it has already stored.

Extra strobes move either pointer forward by one place without moving any data. A synchronous clear input sets both pointers and both marks to zero. The head word is always shown on the read data output. The block reports empty, full and the number of stored words. A write refused because the channel is full, or a read refused because it is empty, gives a one-cycle error pulse.

Top module: `mark_fifo`

## Requirements
- R1: Words are 18 bits wide and the depth is set by parameter DEPTH (512 or 1024). When the channel is not empty, rd_data_o shows the oldest unread word. Words come out in the order they were written.
- R2: count_o equals the write pointer minus the read pointer, where each pointer has one extra wrap bit. empty_o is high when count_o is 0 and full_o is high when count_o equals DEPTH. An accepted write adds one, an accepted read subtracts one, and both together leave the count unchanged.
- R3: A write request (wr_en_i or skip_wr_i) made while full_o is high changes nothing. ovf_o goes high for exactly one cycle, right after that edge.
- R4: A read request (rd_en_i or skip_rd_i) made while empty_o is high changes nothing. udf_o goes high for exactly one cycle, right after that edge.
- R5: save_rd_i copies the read pointer, as it was before the edge, into the read mark. restore_rd_i loads the read pointer from the read mark, so the words after the mark are presented again.
- R6: save_wr_i copies the write pointer into the write mark. restore_wr_i loads the write pointer from the write mark, so later writes replace the words stored from the mark onward.
- R7: skip_rd_i moves the read pointer forward by one without a data transfer. skip_wr_i moves the write pointer forward by one and leaves the storage slot it passes unchanged.
- R8: A restore on one side in the same cycle as a read or write request on that side wins. The request is dropped and gives no error pulse.
- R9: clr_i sets both pointers and both marks to zero. It takes priority over every other strobe in that cycle, and restores after it return a pointer to zero.
- R10: After the asynchronous reset rst_ni, the channel is empty with count_o at 0, and ovf_o and udf_o are low.
- R11: count_o, empty_o and full_o show the new pointer values in the cycle right after a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of pointers and marks |
| wr_en_i | input | 1 | Write wr_data_i at the write pointer |
| wr_data_i | input | 18 | Write data |
| skip_wr_i | input | 1 | Move the write pointer forward without storing |
| rd_en_i | input | 1 | Pop the head word |
| skip_rd_i | input | 1 | Move the read pointer forward without a transfer |
| save_rd_i | input | 1 | Copy the read pointer into the read mark |
| save_wr_i | input | 1 | Copy the write pointer into the write mark |
| restore_rd_i | input | 1 | Load the read pointer from the read mark |
| restore_wr_i | input | 1 | Load the write pointer from the write mark |
| rd_data_o | output | 18 | Head word |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| count_o | output | $clog2(DEPTH)+1 | Stored word count |
| ovf_o | output | 1 | One-cycle pulse for a refused write |
| udf_o | output | 1 | One-cycle pulse for a refused read |

## Verification
Every result of a strobe is due one clock edge after it is applied. The pointers and marks update at that edge, and count_o, the flags and rd_data_o follow from them without further delay. The error pulses are registered at the same edge and are gone after the next one. The bench drives inputs on the falling edge and samples every output on the following falling edge. It compares them with a model that it updates once per rising edge, so each check sits exactly one edge after its stimulus. This includes the cycle right after a restore or a clear.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  localparam int WORD_W = 18;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/mark_fifo_mem.sv
module mark_fifo_mem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // head word shown without a read cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mark_fifo_ptr.sv
module mark_fifo_ptr #(
  parameter int PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] mark_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      mark_o <= '0;
    end else if (clr_i) begin
      ptr_o  <= '0;
      mark_o <= '0;
    end else begin
      if (restore_i)  ptr_o <= mark_o;
      else if (adv_i) ptr_o <= ptr_o + PW'(1);
      if (save_i)     mark_o <= ptr_o;
    end
  end

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_o == '0 && mark_o == '0));
  p_save_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !clr_i) |=> mark_o == $past(ptr_o));
  p_restore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !clr_i) |=> ptr_o == $past(mark_o));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !restore_i && !adv_i) |=> $stable(ptr_o));
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
  import mark_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic [17:0]   wr_data_i,
  input  logic          skip_wr_i,
  input  logic          rd_en_i,
  input  logic          skip_rd_i,
  input  logic          save_rd_i,
  input  logic          save_wr_i,
  input  logic          restore_rd_i,
  input  logic          restore_wr_i,
  output logic [17:0]   rd_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [PW-1:0] count_o,
  output logic          ovf_o,
  output logic          udf_o
);
  logic [PW-1:0] rd_ptr, wr_ptr, rd_mark, wr_mark;
  logic rd_req, wr_req, rd_go, wr_go, store;
  word_t head;

  assign count_o = wr_ptr - rd_ptr;
  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == PW'(DEPTH));

  assign rd_req = rd_en_i | skip_rd_i;
  assign wr_req = wr_en_i | skip_wr_i;
  // restore and clear drop the data operation on their side
  assign rd_go  = rd_req & ~empty_o & ~restore_rd_i & ~clr_i;
  assign wr_go  = wr_req & ~full_o  & ~restore_wr_i & ~clr_i;
  assign store  = wr_go & wr_en_i;

  mark_fifo_ptr #(.PW(PW)) u_rd (
    .clk_i, .rst_ni, .clr_i,
    .adv_i(rd_go), .save_i(save_rd_i), .restore_i(restore_rd_i),
    .ptr_o(rd_ptr), .mark_o(rd_mark)
  );

  mark_fifo_ptr #(.PW(PW)) u_wr (
    .clk_i, .rst_ni, .clr_i,
    .adv_i(wr_go), .save_i(save_wr_i), .restore_i(restore_wr_i),
    .ptr_o(wr_ptr), .mark_o(wr_mark)
  );

  mark_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_mem (
    .clk_i,
    .we_i(store),
    .waddr_i(wr_ptr[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr[AW-1:0]),
    .rdata_o(head)
  );
  assign rd_data_o = head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      ovf_o <= wr_req & full_o  & ~restore_wr_i & ~clr_i;
      udf_o <= rd_req & empty_o & ~restore_rd_i & ~clr_i;
    end
  end

  p_flags_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !restore_wr_i && !clr_i) |=> $stable(wr_ptr));
  p_ovf_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && $past(rst_ni)) |-> $past(full_o));
  p_udf_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udf_o && $past(rst_ni)) |-> $past(empty_o));
  p_restore_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_rd_i |=> !udf_o);
endmodule

// File: tb/sim_mark_fifo.sv
`timescale 1ns/1ps
module sim_mark_fifo;
  localparam int DEPTH = 512;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int M2 = 2 * DEPTH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr, we, sw, re, sr, svr, svw, rsr, rsw;
  logic [17:0] wd, rdat;
  logic emp, ful, ovf, udf;
  logic [CW-1:0] cnt;

  always #2 clk = ~clk;

  mark_fifo #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_en_i(we), .wr_data_i(wd),
    .skip_wr_i(sw), .rd_en_i(re), .skip_rd_i(sr), .save_rd_i(svr),
    .save_wr_i(svw), .restore_rd_i(rsr), .restore_wr_i(rsw),
    .rd_data_o(rdat), .empty_o(emp), .full_o(ful), .count_o(cnt),
    .ovf_o(ovf), .udf_o(udf)
  );

  int n_run = 0, n_fail = 0;
  logic [17:0] mmem [DEPTH];
  int mrd = 0, mwr = 0, mrm = 0, mwm = 0;
  logic eo = 0, eu = 0;

  function automatic int mcount();
    return (mwr - mrd + M2) % M2;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "count", cnt, mcount());
    chk(tag, "empty", emp, mcount() == 0);
    chk(tag, "full", ful, mcount() == DEPTH);
    chk(tag, "ovf", ovf, eo);
    chk(tag, "udf", udf, eu);
    if (mcount() != 0) chk(tag, "data", rdat, mmem[mrd % DEPTH]);
  endtask

  // one cycle: drive at negedge, update model at the edge, compare after it
  task automatic cyc(string tag, bit i_we, bit i_re, bit i_sw, bit i_sr,
                     bit i_svr, bit i_svw, bit i_rsr, bit i_rsw, bit i_clr,
                     logic [17:0] d);
    int c, nrd, nwr;
    we = i_we; re = i_re; sw = i_sw; sr = i_sr; svr = i_svr; svw = i_svw;
    rsr = i_rsr; rsw = i_rsw; clr = i_clr; wd = d;
    @(posedge clk);
    c = mcount(); eo = 0; eu = 0; nrd = mrd; nwr = mwr;
    if (i_clr) begin
      mrd = 0; mwr = 0; mrm = 0; mwm = 0;
    end else begin
      if (i_rsr) nrd = mrm;
      else if (i_re || i_sr) begin
        if (c != 0) nrd = (mrd + 1) % M2; else eu = 1;
      end
      if (i_rsw) nwr = mwm;
      else if (i_we || i_sw) begin
        if (c != DEPTH) begin
          if (i_we) mmem[mwr % DEPTH] = d;
          nwr = (mwr + 1) % M2;
        end else eo = 1;
      end
      if (i_svr) mrm = mrd;
      if (i_svw) mwm = mwr;
      mrd = nrd; mwr = nwr;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0,0,0,0,0,0,0,0,0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-reqs act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    {clr, we, sw, re, sr, svr, svw, rsr, rsw} = '0;
    wd = '0;
    repeat (3) @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10");

    cyc("R4", 0,1,0,0,0,0,0,0,0, '0);
    idle("R4");
    cyc("R4", 0,0,0,1,0,0,0,0,0, '0);

    for (int i = 0; i < DEPTH; i++) cyc("R1", 1,0,0,0,0,0,0,0,0, 18'(i * 37 + 5));
    chk("R2", "full after fill", ful, 1);
    cyc("R3", 1,0,0,0,0,0,0,0,0, 18'h3ffff);
    idle("R3");
    cyc("R3", 0,0,1,0,0,0,0,0,0, '0);
    cyc("R2", 1,1,0,0,0,0,0,0,0, 18'h12345);

    for (int i = 0; i < 3; i++) cyc("R1", 0,1,0,0,0,0,0,0,0, '0);
    cyc("R5", 0,0,0,0,1,0,0,0,0, '0);
    for (int i = 0; i < 5; i++) cyc("R5", 0,1,0,0,0,0,0,0,0, '0);
    cyc("R11", 0,0,0,0,0,0,1,0,0, '0);
    for (int i = 0; i < 5; i++) cyc("R5", 0,1,0,0,0,0,0,0,0, '0);
    cyc("R8", 0,1,0,0,0,0,1,0,0, '0);

    for (int i = 0; i < 20; i++) cyc("R1", 0,1,0,0,0,0,0,0,0, '0);
    cyc("R6", 0,0,0,0,0,1,0,0,0, '0);
    for (int i = 0; i < 4; i++) cyc("R6", 1,0,0,0,0,0,0,0,0, 18'(100 + i));
    cyc("R11", 0,0,0,0,0,0,0,1,0, '0);
    for (int i = 0; i < 4; i++) cyc("R6", 1,0,0,0,0,0,0,0,0, 18'(200 + i));
    cyc("R8", 1,0,0,0,0,0,0,1,0, 18'h2aaaa);

    cyc("R7", 0,0,1,0,0,0,0,0,0, '0);
    cyc("R7", 0,0,0,1,0,0,0,0,0, '0);
    cyc("R7", 0,0,1,1,0,0,0,0,0, '0);

    cyc("R9", 1,1,0,0,1,1,1,1,1, 18'h1);
    cyc("R9", 1,0,0,0,0,0,0,0,0, 18'h77);
    cyc("R9", 0,0,0,0,0,0,0,1,0, '0);
    cyc("R9", 1,1,0,0,0,0,1,0,0, 18'h55);
    idle("R9");

    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      bit bwe = ($urandom_range(0, 99) < 55), bre = ($urandom_range(0, 99) < 50);
      cyc("R2", bwe, bre, r < 3, r >= 3 && r < 6, r >= 6 && r < 8,
          r >= 8 && r < 10, r == 10, r == 11, r == 12, 18'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule